// File: doc/BRIEF.md
# Priority-Aware Pause Flow Controller

This block holds the transmit pause state for an Ethernet transmitter that serves two queues, one high priority and one low priority. The receive path decodes incoming flow-control frames and hands them over as single-cycle events. Each event is either a full pause or a low-queue pause and carries a pause time. The block turns these events into two gating signals. The first, a stop-all signal, halts every transmission at the medium-access layer. The second, a stop-low signal, tells the queue scheduler to stop fetching from the low-priority queue. Frames that already sit in the transmit FIFO still go out.

Only one pause condition is ever active. The most recent event replaces the kind and the remaining time of the one before it. The remaining time drops by one on each slot-time tick, and the pause ends when it reaches zero. A small configuration store holds the flow-control enables and a reject flag. When the reject flag is set, the receive path drops flow-control frames instead of queueing them. The store also holds the 16-bit slot-delay value that goes into the time field of pause frames this station sends. Software loads that value one byte at a time.

Top module: `prio_pause_ctrl`

## Requirements
- R1: A full-pause event (`fc_valid`=1, `fc_low`=0) with a nonzero time sets `stop_all`=1, `stop_low`=0 and `pause_left` to that time, starting in the cycle after the event.
- R2: A low-queue pause event (`fc_low`=1) with a nonzero time sets `stop_low`=1, `stop_all`=0 and `pause_left` to that time, starting in the cycle after the event.
- R3: A low-queue pause that arrives during a full pause drops `stop_all` in the next cycle, raises `stop_low` and reloads `pause_left` with the new time.
- R4: A full pause that arrives during a low-queue pause raises `stop_all` in the next cycle, drops `stop_low` and reloads `pause_left`.
- R5: Each `slot_tick` without an event lowers a nonzero `pause_left` by one. On the tick that makes it zero, both stop outputs fall. A tick while unpaused has no effect, and a cycle with no tick and no event leaves `pause_left` unchanged.
- R6: An event of either kind with a time of zero clears both stop outputs and `pause_left` in the next cycle.
- R7: When an event and a `slot_tick` fall in the same cycle, the event wins. `pause_left` takes the event's time with no decrement applied.
- R8: The flag byte is written with `cfg_wr`=1 and `cfg_sel`=0. Its bit 0 drives `tx_fc_en`, bit 1 drives `rx_restart_en`, bit 2 drives `rx_restop_en` and bit 3 drives `drop_fc`.
- R9: `cfg_sel`=1 writes bits 7:0 of `slot_delay` and `cfg_sel`=2 writes bits 15:8. Each write leaves the other byte unchanged.
- R10: A synchronous reset clears the pause state, with both stops at 0 and `pause_left` at 0. It also loads `tx_fc_en`=1, `rx_restart_en`=0, `rx_restop_en`=0, `drop_fc`=0 and `slot_delay`=16'h4000.
- R11: Pause events and ticks never change any configuration output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fc_valid | input | 1 | Decoded flow-control event this cycle |
| fc_low | input | 1 | 1 = low-queue pause, 0 = full pause |
| fc_time | input | 16 | Pause time in slot units |
| slot_tick | input | 1 | One slot time has elapsed |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 = flag byte, 1 = slot delay low byte, 2 = slot delay high byte |
| cfg_data | input | 8 | Configuration write data |
| stop_all | output | 1 | Halt all transmission at the medium-access layer |
| stop_low | output | 1 | Halt the low-priority queue at the scheduler |
| pause_left | output | 16 | Remaining pause time |
| drop_fc | output | 1 | Receive path must drop flow-control frames |
| tx_fc_en | output | 1 | Sending of pause frames enabled |
| rx_restart_en | output | 1 | Receive flow control, restart mode enable |
| rx_restop_en | output | 1 | Receive flow control, restop mode enable |
| slot_delay | output | 16 | Time field for outgoing pause frames |

## Verification
A received event and a slot tick can land in the same clock cycle. The event must then take precedence, so the freshly loaded time shows up in full with no decrement. The stimulus table drives a low-queue pause in the same cycle as a tick while a full pause is counting down. The row passes only if the kind switches and `pause_left` equals the new time exactly. Configuration writes that coincide with pause traffic are judged the same way: the pause outputs must follow the event alone and the configuration outputs must follow the write alone.

// File: rtl/prio_pause_pkg.sv
package prio_pause_pkg;

   typedef enum logic [1:0] {
      PS_RUN  = 2'd0,
      PS_FULL = 2'd1,
      PS_LOW  = 2'd2
   } pause_kind_e;

   localparam int FLAG_W       = 4;
   localparam int FLAG_TXFC    = 0;
   localparam int FLAG_RESTART = 1;
   localparam int FLAG_RESTOP  = 2;
   localparam int FLAG_REJECT  = 3;

endpackage

// File: rtl/pause_tracker.sv
module pause_tracker
   import prio_pause_pkg::*;
#(
   parameter int TIME_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ev_valid,
   input  logic              ev_low,
   input  logic [TIME_W-1:0] ev_time,
   input  logic              tick,
   output logic              halt_all,
   output logic              halt_low,
   output logic [TIME_W-1:0] remain
);

   localparam logic [TIME_W-1:0] ZERO = '0;
   localparam logic [TIME_W-1:0] ONE  = TIME_W'(1);

   if (TIME_W < 2) begin : g_bad_width
      $error("pause_tracker: TIME_W must be at least 2");
   end

   pause_kind_e kind_q, kind_d;
   logic [TIME_W-1:0] cnt_q, cnt_d;

   always_comb begin
      kind_d = kind_q;
      cnt_d  = cnt_q;
      if (ev_valid) begin
         if (ev_time == ZERO) begin
            kind_d = PS_RUN;
            cnt_d  = ZERO;
         end else begin
            kind_d = ev_low ? PS_LOW : PS_FULL;
            cnt_d  = ev_time;
         end
      end else if (tick && kind_q != PS_RUN) begin
         if (cnt_q <= ONE) begin
            kind_d = PS_RUN;
            cnt_d  = ZERO;
         end else begin
            cnt_d  = cnt_q - ONE;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         kind_q <= PS_RUN;
         cnt_q  <= ZERO;
      end else begin
         kind_q <= kind_d;
         cnt_q  <= cnt_d;
      end
   end

   assign halt_all = (kind_q == PS_FULL);
   assign halt_low = (kind_q == PS_LOW);
   assign remain   = cnt_q;

   // R1
   full_stop_chk: assert property (@(posedge clk) disable iff (rst)
      (ev_valid && !ev_low && ev_time != ZERO) |=> (halt_all && !halt_low && remain == $past(ev_time)));

   // R2
   low_stop_chk: assert property (@(posedge clk) disable iff (rst)
      (ev_valid && ev_low && ev_time != ZERO) |=> (halt_low && !halt_all && remain == $past(ev_time)));

   // R5
   count_down_chk: assert property (@(posedge clk) disable iff (rst)
      (!ev_valid && tick && remain > ONE) |=> (remain == $past(remain) - ONE));

   // R5
   count_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!ev_valid && !tick) |=> $stable(remain));

   // R6
   zero_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (ev_valid && ev_time == ZERO) |=> (!halt_all && !halt_low && remain == ZERO));

endmodule

// File: rtl/fc_cfg_store.sv
module fc_cfg_store
   import prio_pause_pkg::*;
#(
   parameter int                  TIME_W    = 16,
   parameter int                  SEL_W     = 2,
   parameter logic [TIME_W-1:0]   DEF_DELAY = 16'h4000,
   parameter logic [FLAG_W-1:0]   DEF_FLAGS = 4'b0001
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr,
   input  logic [SEL_W-1:0]  sel,
   input  logic [7:0]        data,
   output logic [FLAG_W-1:0] flags,
   output logic [TIME_W-1:0] delay
);

   localparam int NBYTES = TIME_W / 8;

   if (TIME_W % 8 != 0) begin : g_bad_bytes
      $error("fc_cfg_store: TIME_W must be a whole number of bytes");
   end
   if ((NBYTES + 1) > (1 << SEL_W)) begin : g_bad_sel
      $error("fc_cfg_store: SEL_W too narrow for the byte count");
   end

   logic [FLAG_W-1:0] flags_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         flags_q <= DEF_FLAGS;
      end else if (wr && sel == '0) begin
         flags_q <= data[FLAG_W-1:0];
      end
   end

   for (genvar g = 0; g < NBYTES; g++) begin : g_delay_byte
      logic [7:0] byte_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            byte_q <= DEF_DELAY[g*8 +: 8];
         end else if (wr && sel == SEL_W'(g + 1)) begin
            byte_q <= data;
         end
      end
      assign delay[g*8 +: 8] = byte_q;
   end

   assign flags = flags_q;

   // R11
   cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !wr |=> ($stable(flags) && $stable(delay)));

   // R10
   cfg_default_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (flags == DEF_FLAGS && delay == DEF_DELAY));

   // R8
   flag_write_chk: assert property (@(posedge clk) disable iff (rst)
      (wr && sel == '0) |=> (flags == $past(data[FLAG_W-1:0])));

endmodule

// File: rtl/prio_pause_ctrl.sv
module prio_pause_ctrl
   import prio_pause_pkg::*;
#(
   parameter int                TIME_W    = 16,
   parameter int                SEL_W     = 2,
   parameter logic [TIME_W-1:0] DEF_DELAY = 16'h4000
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fc_valid,
   input  logic              fc_low,
   input  logic [TIME_W-1:0] fc_time,
   input  logic              slot_tick,
   input  logic              cfg_wr,
   input  logic [SEL_W-1:0]  cfg_sel,
   input  logic [7:0]        cfg_data,
   output logic              stop_all,
   output logic              stop_low,
   output logic [TIME_W-1:0] pause_left,
   output logic              drop_fc,
   output logic              tx_fc_en,
   output logic              rx_restart_en,
   output logic              rx_restop_en,
   output logic [TIME_W-1:0] slot_delay
);

   logic [FLAG_W-1:0] flags;

   pause_tracker #(
      .TIME_W (TIME_W)
   ) u_track (
      .clk      (clk),
      .rst      (rst),
      .ev_valid (fc_valid),
      .ev_low   (fc_low),
      .ev_time  (fc_time),
      .tick     (slot_tick),
      .halt_all (stop_all),
      .halt_low (stop_low),
      .remain   (pause_left)
   );

   fc_cfg_store #(
      .TIME_W    (TIME_W),
      .SEL_W     (SEL_W),
      .DEF_DELAY (DEF_DELAY),
      .DEF_FLAGS (4'b0001)
   ) u_cfg (
      .clk   (clk),
      .rst   (rst),
      .wr    (cfg_wr),
      .sel   (cfg_sel),
      .data  (cfg_data),
      .flags (flags),
      .delay (slot_delay)
   );

   assign tx_fc_en      = flags[FLAG_TXFC];
   assign rx_restart_en = flags[FLAG_RESTART];
   assign rx_restop_en  = flags[FLAG_RESTOP];
   assign drop_fc       = flags[FLAG_REJECT];

   // R3
   stop_excl_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({stop_all, stop_low}));

   // R5
   idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (!stop_all && !stop_low) |-> (pause_left == '0));

   // R7
   event_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (fc_valid && slot_tick) |=> (pause_left == $past(fc_time)));

   // R4
   full_over_low_chk: assert property (@(posedge clk) disable iff (rst)
      (stop_low && fc_valid && !fc_low && fc_time != '0) |=> stop_all);

endmodule

// File: tb/prio_pause_ctrl_bench.sv
module prio_pause_ctrl_bench;

   logic        clk = 1'b0;
   logic        rst;
   logic        fc_valid, fc_low, slot_tick, cfg_wr;
   logic [15:0] fc_time;
   logic [1:0]  cfg_sel;
   logic [7:0]  cfg_data;
   logic        stop_all, stop_low, drop_fc, tx_fc_en, rx_restart_en, rx_restop_en;
   logic [15:0] pause_left, slot_delay;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   prio_pause_ctrl u_prio_pause_ctrl (
      .clk(clk), .rst(rst), .fc_valid(fc_valid), .fc_low(fc_low), .fc_time(fc_time),
      .slot_tick(slot_tick), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
      .stop_all(stop_all), .stop_low(stop_low), .pause_left(pause_left), .drop_fc(drop_fc),
      .tx_fc_en(tx_fc_en), .rx_restart_en(rx_restart_en), .rx_restop_en(rx_restop_en),
      .slot_delay(slot_delay)
   );

   // vector: {ev, low, time[15:0], tick, exp_all, exp_low, exp_left[15:0]}
   localparam int NV = 15;
   localparam logic [36:0] VEC [NV] = '{
      {1'b1, 1'b0, 16'd5, 1'b0, 1'b1, 1'b0, 16'd5},   // R1 full pause
      {1'b0, 1'b0, 16'd0, 1'b1, 1'b1, 1'b0, 16'd4},   // R5 tick
      {1'b0, 1'b0, 16'd0, 1'b0, 1'b1, 1'b0, 16'd4},   // R5 hold
      {1'b0, 1'b0, 16'd0, 1'b1, 1'b1, 1'b0, 16'd3},   // R5 tick
      {1'b1, 1'b1, 16'd7, 1'b0, 1'b0, 1'b1, 16'd7},   // R3 low over full
      {1'b0, 1'b0, 16'd0, 1'b1, 1'b0, 1'b1, 16'd6},   // R2 counting low
      {1'b1, 1'b0, 16'd3, 1'b0, 1'b1, 1'b0, 16'd3},   // R4 full over low
      {1'b1, 1'b1, 16'd2, 1'b1, 1'b0, 1'b1, 16'd2},   // R7 event with tick
      {1'b0, 1'b0, 16'd0, 1'b1, 1'b0, 1'b1, 16'd1},   // R5 tick
      {1'b0, 1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 16'd0},   // R5 expiry
      {1'b0, 1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 16'd0},   // R5 tick while idle
      {1'b1, 1'b0, 16'd9, 1'b0, 1'b1, 1'b0, 16'd9},   // R1 full pause
      {1'b1, 1'b1, 16'd0, 1'b0, 1'b0, 1'b0, 16'd0},   // R6 zero time clears
      {1'b1, 1'b1, 16'd1, 1'b0, 1'b0, 1'b1, 16'd1},   // R2 low pause
      {1'b0, 1'b0, 16'd0, 1'b1, 1'b0, 1'b0, 16'd0}    // R5 expiry from one
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic idle_inputs();
      fc_valid = 1'b0; fc_low = 1'b0; fc_time = '0; slot_tick = 1'b0;
      cfg_wr = 1'b0; cfg_sel = '0; cfg_data = '0;
   endtask

   task automatic cfg_write(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = s; cfg_data = d;
      @(posedge clk); #1;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   initial begin
      #(4ns * 100000);
      errors++; checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      idle_inputs();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      #1;
      // R10 reset state
      chk("R10 stop_all", 32'(stop_all), 32'd0);
      chk("R10 stop_low", 32'(stop_low), 32'd0);
      chk("R10 pause_left", 32'(pause_left), 32'd0);
      chk("R10 flags", 32'({drop_fc, rx_restop_en, rx_restart_en, tx_fc_en}), 32'h1);
      chk("R10 slot_delay", 32'(slot_delay), 32'h4000);

      // table walk (R1 R2 R3 R4 R5 R6 R7)
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         fc_valid  = VEC[i][36];
         fc_low    = VEC[i][35];
         fc_time   = VEC[i][34:19];
         slot_tick = VEC[i][18];
         @(posedge clk); #1;
         checks++;
         if ({stop_all, stop_low, pause_left} !== VEC[i][17:0]) begin
            errors++;
            $display("FAIL table step %0d (R1 R2 R3 R4 R5 R6 R7) act=%h exp=%h",
                     i, {stop_all, stop_low, pause_left}, VEC[i][17:0]);
         end
      end
      @(negedge clk); idle_inputs();

      // R8 flag byte
      cfg_write(2'd0, 8'h0E);
      chk("R8 flags write", 32'({drop_fc, rx_restop_en, rx_restart_en, tx_fc_en}), 32'hE);
      chk("R8 drop_fc set", 32'(drop_fc), 32'd1);

      // R9 slot delay bytes
      cfg_write(2'd1, 8'h34);
      chk("R9 low byte", 32'(slot_delay), 32'h4034);
      cfg_write(2'd2, 8'h12);
      chk("R9 high byte", 32'(slot_delay), 32'h1234);

      // R11 events and ticks do not touch configuration
      @(negedge clk);
      fc_valid = 1'b1; fc_low = 1'b0; fc_time = 16'd2; slot_tick = 1'b1;
      @(posedge clk); #1;
      @(negedge clk);
      fc_valid = 1'b0; slot_tick = 1'b1;
      @(posedge clk); #1;
      chk("R11 flags kept", 32'({drop_fc, rx_restop_en, rx_restart_en, tx_fc_en}), 32'hE);
      chk("R11 delay kept", 32'(slot_delay), 32'h1234);
      chk("R5 countdown with cfg", 32'(pause_left), 32'd1);

      // R8 clear reject while a write and event coincide
      @(negedge clk);
      slot_tick = 1'b0;
      fc_valid = 1'b1; fc_low = 1'b1; fc_time = 16'd4;
      cfg_wr = 1'b1; cfg_sel = 2'd0; cfg_data = 8'h01;
      @(posedge clk); #1;
      chk("R8 drop_fc cleared", 32'(drop_fc), 32'd0);
      chk("R2 low with cfg write", 32'({stop_all, stop_low, pause_left}), {14'd0, 2'b01, 16'd4});

      // R10 reset during pause restores defaults
      @(negedge clk);
      idle_inputs(); rst = 1'b1;
      @(posedge clk); #1;
      @(negedge clk); rst = 1'b0;
      chk("R10 pause cleared", 32'({stop_all, stop_low, pause_left}), 32'd0);
      chk("R10 delay default", 32'(slot_delay), 32'h4000);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule